// File: doc/BRIEF.md
# Digital PLL Lock Detector

This block decides whether a phase-locked loop is in lock by looking at the error pulses from its phase/frequency detector. A fast sampling clock counts how many samples in each reference cycle have either the pump-up or the pump-down pulse high. That count is the phase-error width of the cycle. A one-clock strobe marks the end of each reference cycle. On that strobe the width is judged, and the measurement then starts again from zero.

The detector has hysteresis. To enter lock, a run of consecutive cycles must each have a width below a tight entry threshold. The run length is three cycles normally and five when the precision input is high. Once in lock, the flag stays high until a single cycle has a width above a looser exit threshold. A clear input is driven whenever the charge pump is tri-stated or the loop is powered down. It forces the detector back to the unlocked state and discards any partial run and any partial measurement. All pins are plain control and status levels. The block has no data stream, so it has no valid/ready handshake and applies no back-pressure.

Top module: `pll_lock_detect`

## Requirements
- R1: While `rst_n` is low, and after it is released, `locked_o` is 0 until a lock run completes.
- R2: The width of a cycle is the number of sampling-clock edges at which `up_i` OR `dn_i` is high. The count covers the edges after the previous strobe up to and including the strobe edge. A sample with both pulses high counts once.
- R3: With `precise_i` = 0 at the strobe, `locked_o` goes high at the strobe edge that ends the 3rd consecutive cycle whose width is below ENTRY_TH (default 4). It is still 0 after the 2nd such cycle.
- R4: With `precise_i` = 1, 5 consecutive cycles below ENTRY_TH are needed. `locked_o` is still 0 after the 4th.
- R5: While unlocked, a cycle with width at or above ENTRY_TH restarts the run from zero.
- R6: While locked, a cycle with width at or below EXIT_TH (default 8) keeps `locked_o` high. This includes widths between the two thresholds.
- R7: While locked, a single cycle with width above EXIT_TH drops `locked_o` at its strobe edge. A new run then starts from zero.
- R8: `clear_i` high at a clock edge forces `locked_o` to 0 and zeroes both the run and the measurement. It takes precedence over a strobe at the same edge.
- R9: `locked_o` changes only at a clock edge where `ref_strobe_i` or `clear_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_i | input | 1 | Pump-up error pulse from the phase detector |
| dn_i | input | 1 | Pump-down error pulse from the phase detector |
| ref_strobe_i | input | 1 | One-clock strobe at the end of each reference cycle |
| precise_i | input | 1 | Run length select: 0 gives 3 cycles, 1 gives 5 cycles |
| clear_i | input | 1 | Tri-state/powerdown clear that forces the unlocked state |
| locked_o | output | 1 | Lock flag |

## Verification
The embedded assertions check, on every cycle, the following properties:
- the clear input always leaves the flag low;
- the flag never moves between strobes;
- lock is gained only at a strobe;
- the measurement counter and the run counter stay within their bounds.

Only the bench's scenarios can show the counting and threshold rules:
- lock arrives after exactly three or five good cycles;
- the entry and exit boundary widths are handled correctly;
- a single bad cycle drops lock;
- overlapping up and down pulses count once.

// File: rtl/lkd_pkg.sv
package lkd_pkg;
  typedef enum logic {
    LKD_SEEK = 1'b0,
    LKD_HELD = 1'b1
  } lkd_state_e;
endpackage

// File: rtl/lkd_err_meter.sv
module lkd_err_meter #(
  parameter int EXIT_TH = 8,
  parameter int ERR_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             strobe_i,
  input  logic             active_i,
  output logic [ERR_W-1:0] width_o
);
  localparam logic [ERR_W-1:0] SAT = ERR_W'(EXIT_TH + 1);

  logic [ERR_W-1:0] acc_q;
  logic [ERR_W:0]   sum;

  // Width of the cycle that ends at this edge, including this sample.
  always_comb begin
    sum     = {1'b0, acc_q} + {{ERR_W{1'b0}}, active_i};
    width_o = (sum > {1'b0, SAT}) ? SAT : sum[ERR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i || strobe_i) acc_q <= '0;
    else                               acc_q <= width_o;
  end

  assert_meter_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q <= SAT);
  assert_meter_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> acc_q == '0);
endmodule

// File: rtl/lkd_lock_fsm.sv
module lkd_lock_fsm
  import lkd_pkg::*;
#(
  parameter int ENTRY_TH = 4,
  parameter int EXIT_TH  = 8,
  parameter int RUN_LO   = 3,
  parameter int RUN_HI   = 5,
  parameter int ERR_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             strobe_i,
  input  logic             precise_i,
  input  logic [ERR_W-1:0] width_i,
  output logic             locked_o
);
  localparam int RUN_W = $clog2(RUN_HI + 1);
  localparam logic [ERR_W-1:0] ENTRY_V = ERR_W'(ENTRY_TH);
  localparam logic [ERR_W-1:0] EXIT_V  = ERR_W'(EXIT_TH);
  localparam logic [RUN_W-1:0] LO_V    = RUN_W'(RUN_LO);
  localparam logic [RUN_W-1:0] HI_V    = RUN_W'(RUN_HI);

  lkd_state_e       st_q;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_nx;
  logic [RUN_W-1:0] need;
  logic             good;

  always_comb begin
    need   = precise_i ? HI_V : LO_V;
    good   = width_i < ENTRY_V;
    run_nx = run_q + RUN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      st_q  <= LKD_SEEK;
      run_q <= '0;
    end else if (strobe_i) begin
      case (st_q)
        LKD_SEEK: begin
          if (!good) begin
            run_q <= '0;
          end else if (run_nx >= need) begin
            st_q  <= LKD_HELD;
            run_q <= '0;
          end else begin
            run_q <= run_nx;
          end
        end
        default: begin
          if (width_i > EXIT_V) st_q <= LKD_SEEK;
          run_q <= '0;
        end
      endcase
    end
  end

  assign locked_o = (st_q == LKD_HELD);

  assert_run_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q < HI_V);
  assert_clear_unlocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !locked_o);
  assert_lock_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked_o && !clear_i && !strobe_i) |=> !locked_o);
  assert_quiet_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_i && !clear_i) |=> $stable(locked_o));
  assert_seek_run_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |-> run_q == '0);
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect #(
  parameter int ENTRY_TH = 4,
  parameter int EXIT_TH  = 8,
  parameter int RUN_LO   = 3,
  parameter int RUN_HI   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up_i,
  input  logic dn_i,
  input  logic ref_strobe_i,
  input  logic precise_i,
  input  logic clear_i,
  output logic locked_o
);
  localparam int ERR_W = $clog2(EXIT_TH + 3);

  logic [ERR_W-1:0] width;

  lkd_err_meter #(.EXIT_TH(EXIT_TH), .ERR_W(ERR_W)) u_meter (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (clear_i),
    .strobe_i (ref_strobe_i),
    .active_i (up_i | dn_i),
    .width_o  (width)
  );

  lkd_lock_fsm #(
    .ENTRY_TH (ENTRY_TH),
    .EXIT_TH  (EXIT_TH),
    .RUN_LO   (RUN_LO),
    .RUN_HI   (RUN_HI),
    .ERR_W    (ERR_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (clear_i),
    .strobe_i  (ref_strobe_i),
    .precise_i (precise_i),
    .width_i   (width),
    .locked_o  (locked_o)
  );
endmodule

// File: tb/test_pll_lock_detect.sv
module test_pll_lock_detect;
  localparam int ENTRY = 4;
  localparam int EXITT = 8;
  localparam int LEN   = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_i = 1'b0, dn_i = 1'b0, ref_strobe_i = 1'b0, precise_i = 1'b0, clear_i = 1'b0;
  logic locked_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  integer m_acc = 0, m_run = 0;
  bit     m_lock = 1'b0;

  always #10 clk = ~clk;

  pll_lock_detect i_pll_lock_detect (
    .clk(clk), .rst_n(rst_n), .up_i(up_i), .dn_i(dn_i),
    .ref_strobe_i(ref_strobe_i), .precise_i(precise_i),
    .clear_i(clear_i), .locked_o(locked_o)
  );

  // Behavioural reference model (R9 every clock)
  always @(posedge clk) begin
    integer w;
    integer need;
    if (!rst_n || clear_i) begin
      m_acc = 0; m_run = 0; m_lock = 1'b0;
    end else begin
      w = m_acc + ((up_i || dn_i) ? 1 : 0);
      if (ref_strobe_i) begin
        need = precise_i ? 5 : 3;
        if (m_lock) begin
          if (w > EXITT) m_lock = 1'b0;
          m_run = 0;
        end else if (w < ENTRY) begin
          m_run = m_run + 1;
          if (m_run >= need) begin m_lock = 1'b1; m_run = 0; end
        end else begin
          m_run = 0;
        end
        m_acc = 0;
      end else begin
        m_acc = w;
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    n_checks++;
    if (locked_o !== m_lock) begin
      n_fail++;
      $display("FAIL R9 model compare at cycle %0d: actual %b expected %b", cyc, locked_o, m_lock);
    end
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired: actual %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic check(input logic exp, input string tag);
    n_checks++;
    if (locked_o !== exp) begin
      n_fail++;
      $display("FAIL %s: locked_o actual %b expected %b", tag, locked_o, exp);
    end
  endtask

  // One reference cycle: width error samples, strobe on the last clock,
  // then one idle clock at whose negedge the flag is checked.
  task automatic ref_cycle(input int width, input bit both, input logic exp, input string tag);
    for (int i = 0; i < LEN; i++) begin
      @(negedge clk);
      up_i = (i < width) && (both || (i % 2 == 0));
      dn_i = (i < width) && (both || (i % 2 == 1));
      ref_strobe_i = (i == LEN - 1);
    end
    @(negedge clk);
    check(exp, tag);
    up_i = 1'b0; dn_i = 1'b0; ref_strobe_i = 1'b0;
  endtask

  task automatic pulse_clear(input string tag);
    @(negedge clk);
    clear_i = 1'b1;
    @(negedge clk);
    check(1'b0, tag);
    clear_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1'b0, "R1 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(1'b0, "R1 after reset");

    // R3: three good cycles at normal precision
    ref_cycle(2, 0, 1'b0, "R3 good 1");
    ref_cycle(3, 0, 1'b0, "R3 good 2");
    ref_cycle(0, 0, 1'b1, "R3 good 3 locks");
    // R6: between thresholds and exactly at exit threshold
    ref_cycle(6, 0, 1'b1, "R6 width 6 holds");
    ref_cycle(8, 0, 1'b1, "R6 width 8 holds");
    // R7: single bad cycle
    ref_cycle(9, 0, 1'b0, "R7 width 9 drops");
    // R4: five good cycles with precision
    precise_i = 1'b1;
    for (int k = 0; k < 4; k++) ref_cycle(1, 0, 1'b0, "R4 not yet locked");
    ref_cycle(1, 0, 1'b1, "R4 fifth good locks");
    ref_cycle(11, 0, 1'b0, "R7 width 11 drops");
    precise_i = 1'b0;
    // R5: width at entry threshold resets the run
    ref_cycle(3, 0, 1'b0, "R5 good 1");
    ref_cycle(3, 0, 1'b0, "R5 good 2");
    ref_cycle(4, 0, 1'b0, "R5 width 4 resets run");
    ref_cycle(3, 0, 1'b0, "R5 restart 1");
    ref_cycle(3, 0, 1'b0, "R5 restart 2");
    ref_cycle(3, 0, 1'b1, "R5 restart 3 locks");
    // R8: clear drops lock and partial run
    pulse_clear("R8 clear drops lock");
    ref_cycle(2, 0, 1'b0, "R8 partial 1");
    ref_cycle(2, 0, 1'b0, "R8 partial 2");
    pulse_clear("R8 clear mid run");
    ref_cycle(2, 0, 1'b0, "R8 run restarted 1");
    ref_cycle(2, 0, 1'b0, "R8 run restarted 2");
    ref_cycle(2, 0, 1'b1, "R8 run restarted 3 locks");
    ref_cycle(9, 0, 1'b0, "R7 drop before R2");
    // R2: overlapping up/down count once (3 samples, not 6)
    ref_cycle(3, 1, 1'b0, "R2 overlap 1");
    ref_cycle(3, 1, 1'b0, "R2 overlap 2");
    ref_cycle(3, 1, 1'b1, "R2 overlap 3 locks");
    // R8: clear wins over a strobe at the same edge
    @(negedge clk);
    clear_i = 1'b1; ref_strobe_i = 1'b1;
    @(negedge clk);
    check(1'b0, "R8 clear with strobe");
    clear_i = 1'b0; ref_strobe_i = 1'b0;
    repeat (3) @(negedge clk);
    check(1'b0, "R9 idle stays unlocked");

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule